// File: doc/BRIEF.md
# Register Status and Rename Table

This block is the architectural register file of an out-of-order floating-point cluster, extended so that every register can stand for a result that has not been produced yet. Each entry carries a data value, a busy flag and a 4-bit producer tag. When an instruction is dispatched, the table answers each of its source lookups with one of two things. If the register is settled, it returns the value with tag 0. If the register is still waiting for a result, it returns the tag of the pending producer. The table then binds the instruction's destination register to that instruction's own tag.

Finished results reach the table on a broadcast bus that carries a tag and a value. A waiting register takes the value only when the broadcast tag equals the tag it currently holds. A register that has been renamed again therefore drops the older result without stalling, which is how write-after-write reuse of a name is settled. Two instructions can be dispatched per cycle. The second one sees the rename made by the first. A broadcast in the same cycle is visible to both lookups.

The four registers answer to the addresses 0, 2, 4 and 8. Any other address is rejected and flagged.

Top module: `rs_table`

## Requirements
- R1: While reset is held low at a clock edge, every register becomes not busy with tag 0, and its data is loaded from the INIT_DATA parameter (defaults: register 0 = 6, register 2 = 3, register 4 = 10, register 8 = 7).
- R2: A source lookup of a register that is not busy returns its data with tag 0. A lookup of a busy register returns its producer tag with data 0.
- R3: A valid dispatch marks its destination register busy with the dispatch tag from the next cycle on, replacing any tag the register already held.
- R4: A broadcast whose tag equals a busy register's current tag stores the broadcast value and clears busy at the next edge. A broadcast with any other tag, including an older tag of a renamed register, leaves the register unchanged, and registers that are not busy are never touched.
- R5: An instruction whose destination is also one of its sources receives the operand as it stood before its own rename.
- R6: Slot 1's lookups see the rename made by slot 0 in the same cycle. If both slots name the same destination, slot 1's tag is the one kept.
- R7: If a register matched by a broadcast is looked up in the same cycle, the lookup returns the broadcast value with tag 0.
- R8: If a register matched by a broadcast is renamed in the same cycle, the rename wins: the register stays busy with the new tag.
- R9: Only the addresses 0, 2, 4 and 8 are legal. A valid dispatch with an illegal source or destination address raises that slot's error output and changes no register. An illegal source address looks up as tag 0, data 0.
- R10: A slot with its valid input low still drives lookups, but it renames nothing and keeps its error output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dsp_valid | input | NSLOT | Per slot: the dispatch is real and renames its destination |
| dsp_src_a | input | NSLOT x ADDR_W | Per slot: first source register address |
| dsp_src_b | input | NSLOT x ADDR_W | Per slot: second source register address |
| dsp_dst | input | NSLOT x ADDR_W | Per slot: destination register address |
| dsp_tag | input | NSLOT x TAG_W | Per slot: producer tag of the dispatched instruction (nonzero) |
| bc_valid | input | 1 | A result is on the broadcast bus |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_data | input | DATA_W | Value of the broadcast result |
| opa_tag | output | NSLOT x TAG_W | Per slot: first source tag, 0 when a value is returned |
| opa_data | output | NSLOT x DATA_W | Per slot: first source value, 0 when a tag is returned |
| opb_tag | output | NSLOT x TAG_W | Per slot: second source tag |
| opb_data | output | NSLOT x DATA_W | Per slot: second source value |
| dsp_err | output | NSLOT | Per slot: illegal register address on a valid dispatch |

## Verification
The collision that matters is a broadcast and a dispatch touching the same register in one cycle. It comes in two forms. In the first, the register is only looked up, and the lookup must already return the broadcast value. In the second, the register is also renamed, and the new tag must survive the edge. The bench puts a register in the busy state, then drives the matching broadcast together with a dispatch that both reads and rebinds that register. It checks the returned operand in that cycle and the register's tag one cycle later. A separate sequence pairs a same-cycle double rename with later broadcasts of the older and the newer tag, to show that only the newer tag is accepted.

// File: rtl/rs_table_pkg.sv
// Package: rs_table_pkg
// Shared helpers for the rename table. Register index i answers to the
// architectural address 0 for i == 0 and to (1 << i) otherwise.
package rs_table_pkg;

    // Map a storage index to the architectural register address it decodes.
    function automatic int unsigned reg_addr_of(input int unsigned idx);
        return (idx == 0) ? 0 : (1 << idx);
    endfunction

endpackage

// File: rtl/rs_addr_dec.sv
// Module: rs_addr_dec
// Decodes one register address into a one-hot register select.
// Assumes ADDR_W is wide enough to hold the highest register address.
module rs_addr_dec
    import rs_table_pkg::*;
#(
    parameter int NREG   = 4,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   hit,
    output logic              ok
);

    // One comparator per register against its fixed address.
    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        assign hit[i] = (addr == ADDR_W'(reg_addr_of(i)));
    end

    // The address is legal when some register claims it.
    assign ok = |hit;

endmodule

// File: rtl/rs_snoop.sv
// Module: rs_snoop
// Applies the result broadcast to a view of the table. A busy register
// whose tag equals the broadcast tag becomes settled with the broadcast
// value. Assumes producer tags are nonzero.
module rs_snoop #(
    parameter int NREG   = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic                         bc_valid,
    input  logic [TAG_W-1:0]             bc_tag,
    input  logic [DATA_W-1:0]            bc_data,
    input  logic [NREG-1:0]              busy_i,
    input  logic [NREG-1:0][TAG_W-1:0]   tag_i,
    input  logic [NREG-1:0][DATA_W-1:0]  data_i,
    output logic [NREG-1:0]              busy_o,
    output logic [NREG-1:0][TAG_W-1:0]   tag_o,
    output logic [NREG-1:0][DATA_W-1:0]  data_o
);

    logic [NREG-1:0] match;

    // Per register: capture the broadcast only on a current-tag match.
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        assign match[i]  = bc_valid && busy_i[i] && (tag_i[i] == bc_tag);
        assign busy_o[i] = busy_i[i] && !match[i];
        assign tag_o[i]  = match[i] ? '0 : tag_i[i];
        assign data_o[i] = match[i] ? bc_data : data_i[i];
    end

endmodule

// File: rtl/rs_slot.sv
// Module: rs_slot
// One dispatch slot. Looks up both sources in the incoming view, then
// produces the outgoing view with the destination bound to the new tag.
// An illegal address on a valid dispatch flags an error and suppresses
// the rename. Assumes the incoming view already holds any broadcast and
// any earlier slot's rename.
module rs_slot #(
    parameter int NREG   = 4,
    parameter int ADDR_W = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic                         valid,
    input  logic [ADDR_W-1:0]            src_a,
    input  logic [ADDR_W-1:0]            src_b,
    input  logic [ADDR_W-1:0]            dst,
    input  logic [TAG_W-1:0]             new_tag,
    input  logic [NREG-1:0]              busy_i,
    input  logic [NREG-1:0][TAG_W-1:0]   tag_i,
    input  logic [NREG-1:0][DATA_W-1:0]  data_i,
    output logic [TAG_W-1:0]             opa_tag,
    output logic [DATA_W-1:0]            opa_data,
    output logic [TAG_W-1:0]             opb_tag,
    output logic [DATA_W-1:0]            opb_data,
    output logic                         err,
    output logic [NREG-1:0]              busy_o,
    output logic [NREG-1:0][TAG_W-1:0]   tag_o,
    output logic [NREG-1:0][DATA_W-1:0]  data_o
);

    localparam int NSRC = 2;

    logic [NSRC-1:0][ADDR_W-1:0] src;
    logic [NSRC-1:0][NREG-1:0]   src_hit;
    logic [NSRC-1:0]             src_ok;
    logic [NSRC-1:0][TAG_W-1:0]  op_tag;
    logic [NSRC-1:0][DATA_W-1:0] op_data;
    logic [NREG-1:0]             dst_hit;
    logic                        dst_ok;
    logic                        do_ren;

    assign src[0] = src_a;
    assign src[1] = src_b;

    // Source lookups: decode, then return either the value or the tag.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        rs_addr_dec #(.NREG(NREG), .ADDR_W(ADDR_W)) u_dec (
            .addr (src[s]),
            .hit  (src_hit[s]),
            .ok   (src_ok[s])
        );

        // Operand select: value with tag 0 when settled, tag with data 0 when busy.
        always_comb begin
            op_tag[s]  = '0;
            op_data[s] = '0;
            for (int i = 0; i < NREG; i++) begin
                if (src_hit[s][i]) begin
                    if (busy_i[i]) op_tag[s]  = tag_i[i];
                    else           op_data[s] = data_i[i];
                end
            end
        end
    end

    assign opa_tag  = op_tag[0];
    assign opa_data = op_data[0];
    assign opb_tag  = op_tag[1];
    assign opb_data = op_data[1];

    rs_addr_dec #(.NREG(NREG), .ADDR_W(ADDR_W)) u_dst_dec (
        .addr (dst),
        .hit  (dst_hit),
        .ok   (dst_ok)
    );

    assign err    = valid && !(dst_ok && (&src_ok));
    assign do_ren = valid && dst_ok && (&src_ok);

    // Destination rename: rebind the selected register to the new tag.
    for (genvar i = 0; i < NREG; i++) begin : g_ren
        assign busy_o[i] = busy_i[i] || (do_ren && dst_hit[i]);
        assign tag_o[i]  = (do_ren && dst_hit[i]) ? new_tag : tag_i[i];
        assign data_o[i] = data_i[i];
    end

endmodule

// File: rtl/rs_store.sv
// Module: rs_store
// Holds the table state: busy flags, tags and data. Synchronous
// active-low reset settles every register on its INIT_DATA value.
module rs_store #(
    parameter int NREG   = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    parameter logic [NREG*DATA_W-1:0] INIT_DATA = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NREG-1:0]              busy_d,
    input  logic [NREG-1:0][TAG_W-1:0]   tag_d,
    input  logic [NREG-1:0][DATA_W-1:0]  data_d,
    output logic [NREG-1:0]              busy_q,
    output logic [NREG-1:0][TAG_W-1:0]   tag_q,
    output logic [NREG-1:0][DATA_W-1:0]  data_q
);

    // State register: load the reset image or the fully updated view.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            tag_q  <= '0;
            data_q <= INIT_DATA;
        end else begin
            busy_q <= busy_d;
            tag_q  <= tag_d;
            data_q <= data_d;
        end
    end

endmodule

// File: rtl/rs_table.sv
// Module: rs_table
// Register status and rename table. Lookup order within a cycle:
// broadcast first, then slot 0 lookups and rename, then slot 1 lookups and
// rename. The last view is stored at the clock edge. Lookups are
// combinational. Assumes dispatch tags are nonzero; tag 0 means "value".
module rs_table #(
    parameter int NREG   = 4,
    parameter int NSLOT  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    parameter logic [NREG*DATA_W-1:0] INIT_DATA = {16'd7, 16'd10, 16'd3, 16'd6},
    localparam int ADDR_W = NREG
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSLOT-1:0]              dsp_valid,
    input  logic [NSLOT-1:0][ADDR_W-1:0]  dsp_src_a,
    input  logic [NSLOT-1:0][ADDR_W-1:0]  dsp_src_b,
    input  logic [NSLOT-1:0][ADDR_W-1:0]  dsp_dst,
    input  logic [NSLOT-1:0][TAG_W-1:0]   dsp_tag,
    input  logic                          bc_valid,
    input  logic [TAG_W-1:0]              bc_tag,
    input  logic [DATA_W-1:0]             bc_data,
    output logic [NSLOT-1:0][TAG_W-1:0]   opa_tag,
    output logic [NSLOT-1:0][DATA_W-1:0]  opa_data,
    output logic [NSLOT-1:0][TAG_W-1:0]   opb_tag,
    output logic [NSLOT-1:0][DATA_W-1:0]  opb_data,
    output logic [NSLOT-1:0]              dsp_err
);

    logic [NREG-1:0]              cur_busy;
    logic [NREG-1:0][TAG_W-1:0]   cur_tag;
    logic [NREG-1:0][DATA_W-1:0]  cur_data;

    logic [NSLOT:0][NREG-1:0]             v_busy;
    logic [NSLOT:0][NREG-1:0][TAG_W-1:0]  v_tag;
    logic [NSLOT:0][NREG-1:0][DATA_W-1:0] v_data;

    rs_store #(
        .NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W), .INIT_DATA(INIT_DATA)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_d (v_busy[NSLOT]),
        .tag_d  (v_tag[NSLOT]),
        .data_d (v_data[NSLOT]),
        .busy_q (cur_busy),
        .tag_q  (cur_tag),
        .data_q (cur_data)
    );

    rs_snoop #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .bc_data  (bc_data),
        .busy_i   (cur_busy),
        .tag_i    (cur_tag),
        .data_i   (cur_data),
        .busy_o   (v_busy[0]),
        .tag_o    (v_tag[0]),
        .data_o   (v_data[0])
    );

    // Slot chain: each slot reads the view left by the one before it.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        rs_slot #(
            .NREG(NREG), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
        ) u_slot (
            .valid    (dsp_valid[s]),
            .src_a    (dsp_src_a[s]),
            .src_b    (dsp_src_b[s]),
            .dst      (dsp_dst[s]),
            .new_tag  (dsp_tag[s]),
            .busy_i   (v_busy[s]),
            .tag_i    (v_tag[s]),
            .data_i   (v_data[s]),
            .opa_tag  (opa_tag[s]),
            .opa_data (opa_data[s]),
            .opb_tag  (opb_tag[s]),
            .opb_data (opb_data[s]),
            .err      (dsp_err[s]),
            .busy_o   (v_busy[s+1]),
            .tag_o    (v_tag[s+1]),
            .data_o   (v_data[s+1])
        );
    end

endmodule

// File: rtl/rs_table_chk.sv
// Module: rs_table_chk
// Property checker for rs_table, attached by the bind at the end of file.
module rs_table_chk #(
    parameter int NREG   = 4,
    parameter int NSLOT  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NSLOT-1:0]              dsp_valid,
    input logic [NSLOT-1:0][ADDR_W-1:0]  dsp_src_a,
    input logic [NSLOT-1:0][ADDR_W-1:0]  dsp_dst,
    input logic [NSLOT-1:0][TAG_W-1:0]   dsp_tag,
    input logic [NSLOT-1:0]              dsp_err,
    input logic [NSLOT-1:0][TAG_W-1:0]   opa_tag,
    input logic [NSLOT-1:0][DATA_W-1:0]  opa_data,
    input logic [NSLOT-1:0][TAG_W-1:0]   opb_tag,
    input logic [NSLOT-1:0][DATA_W-1:0]  opb_data,
    input logic                          bc_valid,
    input logic [TAG_W-1:0]              bc_tag,
    input logic [NREG-1:0]               cur_busy,
    input logic [NREG-1:0][TAG_W-1:0]    cur_tag,
    input logic [NREG-1:0][DATA_W-1:0]   cur_data
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // A returned tag never comes with data.
        assert_tag_no_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (opa_tag[s] != '0) |-> (opa_data[s] == '0));
        assert_tag_no_data_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (opb_tag[s] != '0) |-> (opb_data[s] == '0));
        // An address with more than one bit set is never a register.
        assert_bad_dst_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (dsp_valid[s] && ($countones(dsp_dst[s]) > 1)) |-> dsp_err[s]);
    end

    if (NSLOT > 1) begin : g_pair
        // Slot 1 sees slot 0's rename in the same cycle.
        assert_second_sees_rename_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (dsp_valid[0] && !dsp_err[0] && (dsp_src_a[1] == dsp_dst[0]))
            |-> (opa_tag[1] == dsp_tag[0]));
    end

    // A rejected lone dispatch without broadcast leaves all state alone.
    assert_err_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((dsp_valid == NSLOT'(1)) && dsp_err[0] && !bc_valid)
        |=> ($stable(cur_busy) && $stable(cur_tag) && $stable(cur_data)));

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Busy holds until some broadcast arrives.
        assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cur_busy[i] && !bc_valid) |=> cur_busy[i]);
        // Tag of a busy register holds without a match or a dispatch.
        assert_tag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cur_busy[i] && !(bc_valid && (bc_tag == cur_tag[i])) && (dsp_valid == '0))
            |=> $stable(cur_tag[i]));
    end

endmodule

bind rs_table rs_table_chk #(
    .NREG(NREG), .NSLOT(NSLOT), .TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dsp_valid (dsp_valid),
    .dsp_src_a (dsp_src_a),
    .dsp_dst   (dsp_dst),
    .dsp_tag   (dsp_tag),
    .dsp_err   (dsp_err),
    .opa_tag   (opa_tag),
    .opa_data  (opa_data),
    .opb_tag   (opb_tag),
    .opb_data  (opb_data),
    .bc_valid  (bc_valid),
    .bc_tag    (bc_tag),
    .cur_busy  (cur_busy),
    .cur_tag   (cur_tag),
    .cur_data  (cur_data)
);

// File: tb/rs_table_bench.sv
// Scoreboard bench for rs_table: the driver queues expected lookup results,
// the monitor compares them against the outputs mid-cycle.
module rs_table_bench;

    localparam int NSLOT  = 2;
    localparam int ADDR_W = 4;
    localparam int TAG_W  = 4;
    localparam int DATA_W = 16;

    // Field codes: 0 opa_tag, 1 opa_data, 2 opb_tag, 3 opb_data, 4 err
    typedef struct {
        int    slot;
        int    field;
        int    exp;
        string req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSLOT-1:0]             dsp_valid;
    logic [NSLOT-1:0][ADDR_W-1:0] dsp_src_a;
    logic [NSLOT-1:0][ADDR_W-1:0] dsp_src_b;
    logic [NSLOT-1:0][ADDR_W-1:0] dsp_dst;
    logic [NSLOT-1:0][TAG_W-1:0]  dsp_tag;
    logic                         bc_valid;
    logic [TAG_W-1:0]             bc_tag;
    logic [DATA_W-1:0]            bc_data;
    logic [NSLOT-1:0][TAG_W-1:0]  opa_tag;
    logic [NSLOT-1:0][DATA_W-1:0] opa_data;
    logic [NSLOT-1:0][TAG_W-1:0]  opb_tag;
    logic [NSLOT-1:0][DATA_W-1:0] opb_data;
    logic [NSLOT-1:0]             dsp_err;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    item_t sb[$];
    event  chk_ev;

    always #2 clk = ~clk;

    rs_table u_rs_table (
        .clk(clk), .rst_n(rst_n),
        .dsp_valid(dsp_valid), .dsp_src_a(dsp_src_a), .dsp_src_b(dsp_src_b),
        .dsp_dst(dsp_dst), .dsp_tag(dsp_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .opa_tag(opa_tag), .opa_data(opa_data), .opb_tag(opb_tag),
        .opb_data(opb_data), .dsp_err(dsp_err)
    );

    function automatic int actual(input int s, input int f);
        case (f)
            0:       return int'(opa_tag[s]);
            1:       return int'(opa_data[s]);
            2:       return int'(opb_tag[s]);
            3:       return int'(opb_data[s]);
            default: return int'(dsp_err[s]);
        endcase
    endfunction

    // Monitor: pop every queued expectation and compare mid-cycle.
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (actual(it.slot, it.field) != it.exp) begin
                    failures++;
                    $display("FAIL %s slot%0d field%0d actual=%0d expected=%0d",
                             it.req, it.slot, it.field, actual(it.slot, it.field), it.exp);
                end
            end
        end
    end

    task automatic clr();
        dsp_valid = '0; dsp_src_a = '0; dsp_src_b = '0;
        dsp_dst = '0; dsp_tag = '0;
        bc_valid = 1'b0; bc_tag = '0; bc_data = '0;
    endtask

    task automatic slot(input int s, input bit v, input int a, input int b,
                        input int d, input int t);
        dsp_valid[s] = v;
        dsp_src_a[s] = ADDR_W'(a);
        dsp_src_b[s] = ADDR_W'(b);
        dsp_dst[s]   = ADDR_W'(d);
        dsp_tag[s]   = TAG_W'(t);
    endtask

    task automatic rd(input int s, input int a, input int b);
        slot(s, 1'b0, a, b, 0, 0);
    endtask

    task automatic bcast(input int t, input int d);
        bc_valid = 1'b1; bc_tag = TAG_W'(t); bc_data = DATA_W'(d);
    endtask

    task automatic want(input int s, input int f, input int v, input string r);
        item_t it;
        it.slot = s; it.field = f; it.exp = v; it.req = r;
        sb.push_back(it);
    endtask

    task automatic fire();
        -> chk_ev;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run is one failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Driver: scenario sequence.
    initial begin
        clr();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 reset image
        clr(); rd(0, 0, 2); rd(1, 4, 8);
        want(0, 0, 0, "R1"); want(0, 1, 6, "R1"); want(0, 3, 3, "R1");
        want(1, 1, 10, "R1"); want(1, 2, 0, "R2"); want(1, 3, 7, "R1");
        want(0, 4, 0, "R10");
        fire();

        // R5: r2 <- r2 op r4, tag 1
        clr(); slot(0, 1, 2, 4, 2, 1);
        want(0, 0, 0, "R5"); want(0, 1, 3, "R5"); want(0, 3, 10, "R2");
        want(0, 4, 0, "R3");
        fire();

        clr(); rd(0, 2, 0);
        want(0, 0, 1, "R3"); want(0, 1, 0, "R2"); want(0, 3, 6, "R2");
        fire();

        // R6: slot0 renames r2 tag 3, slot1 reads r2 and renames r8 tag 5
        clr(); slot(0, 1, 0, 8, 2, 3); slot(1, 1, 2, 0, 8, 5);
        want(1, 0, 3, "R6"); want(1, 1, 0, "R6"); want(0, 3, 7, "R2");
        fire();

        clr(); rd(0, 2, 8);
        want(0, 0, 3, "R3"); want(0, 2, 5, "R3");
        fire();

        // R4: stale tag 1 must be ignored
        clr(); bcast(1, 99); rd(0, 2, 2);
        want(0, 0, 3, "R4"); want(0, 1, 0, "R4");
        fire();
        clr(); rd(0, 2, 2);
        want(0, 0, 3, "R4");
        fire();

        // R7: matching broadcast seen by a same-cycle lookup
        clr(); bcast(3, 42); rd(0, 2, 8);
        want(0, 0, 0, "R7"); want(0, 1, 42, "R7"); want(0, 2, 5, "R4");
        fire();
        clr(); bcast(5, 55); rd(0, 2, 0);
        want(0, 0, 0, "R4"); want(0, 1, 42, "R4"); want(0, 3, 6, "R4");
        fire();
        clr(); rd(0, 8, 0);
        want(0, 0, 0, "R4"); want(0, 1, 55, "R4"); want(0, 3, 6, "R4");
        fire();

        // R8: broadcast match and rename of r4 in one cycle
        clr(); slot(0, 1, 0, 0, 4, 7);
        fire();
        clr(); bcast(7, 11); slot(0, 1, 4, 4, 4, 9);
        want(0, 0, 0, "R7"); want(0, 1, 11, "R7"); want(0, 3, 11, "R5");
        fire();
        clr(); rd(0, 4, 4);
        want(0, 0, 9, "R8"); want(0, 1, 0, "R8");
        fire();
        clr(); bcast(9, 12); fire();
        clr(); rd(0, 4, 0);
        want(0, 0, 0, "R4"); want(0, 1, 12, "R4");
        fire();

        // R6: both slots rename r0, slot 1 wins
        clr(); slot(0, 1, 2, 2, 0, 10); slot(1, 1, 2, 2, 0, 11);
        fire();
        clr(); rd(1, 0, 0);
        want(1, 0, 11, "R6");
        fire();
        clr(); bcast(10, 1); rd(0, 0, 0);
        want(0, 0, 11, "R4"); want(0, 1, 0, "R4");
        fire();
        clr(); bcast(11, 2); rd(0, 0, 0);
        want(0, 0, 0, "R7"); want(0, 1, 2, "R7");
        fire();

        // R9: illegal destination 3, illegal source 5
        clr(); slot(0, 1, 5, 0, 3, 12);
        want(0, 4, 1, "R9"); want(0, 0, 0, "R9"); want(0, 1, 0, "R9");
        want(0, 3, 2, "R9"); want(1, 4, 0, "R10");
        fire();
        // R9: legal destination, illegal source 6
        clr(); slot(0, 1, 2, 6, 2, 13);
        want(0, 4, 1, "R9"); want(0, 1, 42, "R9");
        fire();
        clr(); rd(0, 2, 4);
        want(0, 0, 0, "R9"); want(0, 1, 42, "R9"); want(0, 3, 12, "R9");
        fire();

        // R10: invalid slot does not rename
        clr(); slot(0, 0, 2, 2, 2, 14);
        want(0, 4, 0, "R10");
        fire();
        clr(); rd(0, 2, 2);
        want(0, 0, 0, "R10"); want(0, 1, 42, "R10");
        fire();

        // R1: reset mid-run restores the image
        clr(); slot(0, 1, 0, 0, 2, 15);
        fire();
        rst_n = 1'b0;
        clr();
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        rd(0, 2, 4);
        want(0, 0, 0, "R1"); want(0, 1, 3, "R1"); want(0, 3, 10, "R1");
        fire();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule